// File: doc/BRIEF.md
# Fibonacci LED Stepper

This block walks through the Fibonacci sequence and drives the current term onto a bank of LEDs as a plain binary number. An advance pulse moves the display to the following term. A restart pulse sends the display back to the first term. Both pulses arrive already debounced and edge-detected, each lasting exactly one clock cycle.

The block keeps the successor of the shown term one bit wider than the display. When an advance would bring up a term that no longer fits, the block does not show a wrapped value. It flashes every LED on and off for a fixed number of times and then starts the sequence again by itself. A parameter sets how many clock cycles each on or off phase lasts. A second parameter sets the number of flashes.

Top module: `fib_led_stepper`

## Requirements
- R1: While `rst` is high at a rising edge, the block returns to the start of the sequence. After that edge, `led_o` shows 0, and the next advances show 1, 1, 2, and so on.
- R2: Each `step_i` pulse in the normal display state makes `led_o` show the next Fibonacci term, from the edge that samples the pulse. With 8 LEDs the terms are 0, 1, 1, 2, 3, 5, 8, 13, 21, 34, 55, 89, 144, 233.
- R3: A `restart_i` pulse sets `led_o` to 0 after that edge, whether the block is displaying a term or flashing.
- R4: When `restart_i` and `step_i` are high in the same cycle, the restart wins and `led_o` shows 0.
- R5: An advance whose next term would need more than WIDTH bits starts the flash sequence and shows no wrapped value. This is the advance that follows 233 when the display is 8 LEDs wide. The first flash phase begins at the edge that samples the advance.
- R6: The flash sequence has BLINKS on phases and BLINKS off phases, on and off taking turns and starting with on. Each phase lasts HOLD_CYCLES cycles. During an on phase `led_o` is all ones, and during an off phase it is all zeros.
- R7: When the last off phase ends, the block returns to the start of the sequence by itself. `led_o` then shows 0, and the next advances show 1, 1, 2.
- R8: `step_i` pulses during the flash sequence are ignored. They neither shorten nor lengthen any phase, and they do not change the term shown after the sequence ends.
- R9: With no pulse on either input, `led_o` keeps showing the current term.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_i | input | 1 | Single-cycle pulse that advances to the next term |
| restart_i | input | 1 | Single-cycle pulse that returns to the first term |
| led_o | output | WIDTH | Current term in binary, or the flash pattern |

## Verification
Assertions run on every cycle. They check the following:
- a restart clears the display, even in the cycle of an advance;
- an advance that fits shows the previously held successor;
- an advance that overflows enters the flash with every LED lit;
- the flash pattern holds steady within a phase;
- the flash is not cut short by anything but a restart;
- the display returns to 0 when the flash completes.

Only the bench's scenarios show the following:
- the full sequence of values, term by term up to overflow;
- the exact length of each flash phase;
- that advances during the flash leave no trace in the terms that follow.

// File: rtl/fib_led_stepper.sv
module fib_led_stepper #(
  parameter int WIDTH       = 8,
  parameter int HOLD_CYCLES = 12_500_000,
  parameter int BLINKS      = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_i,
  input  logic             restart_i,
  output logic [WIDTH-1:0] led_o
);
  localparam int PHASES = 2 * BLINKS;
  localparam int PW     = $clog2(PHASES + 1);
  localparam int CW     = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;

  logic [WIDTH-1:0] cur;
  logic [WIDTH:0]   nxt;
  logic             blink;
  logic [PW-1:0]    phase;
  logic [CW-1:0]    cnt;

  wire clear     = rst | restart_i;
  wire phase_end = (cnt == CW'(HOLD_CYCLES - 1));
  wire last      = phase_end && (phase == PW'(PHASES - 1));

  always_ff @(posedge clk) begin
    if (clear) begin
      cur   <= '0;
      nxt   <= (WIDTH+1)'(1);
      blink <= 1'b0;
      phase <= '0;
      cnt   <= '0;
    end else if (blink) begin
      if (phase_end) begin
        cnt <= '0;
        if (last) begin
          blink <= 1'b0;
          phase <= '0;
          cur   <= '0;
          nxt   <= (WIDTH+1)'(1);
        end else begin
          phase <= phase + 1'b1;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (step_i) begin
      if (nxt[WIDTH]) begin
        blink <= 1'b1;
        phase <= '0;
        cnt   <= '0;
      end else begin
        cur <= nxt[WIDTH-1:0];
        nxt <= (WIDTH+1)'(cur) + nxt;
      end
    end
  end

  assign led_o = blink ? {WIDTH{~phase[0]}} : cur;

  // R3 R4
  restart_clears_chk: assert property (@(posedge clk) disable iff (rst)
    restart_i |=> led_o == '0);

  // R2
  advance_shows_next_chk: assert property (@(posedge clk) disable iff (rst)
    (!blink && step_i && !restart_i && !nxt[WIDTH]) |=> led_o == $past(nxt[WIDTH-1:0]));

  // R5
  overflow_enters_blink_chk: assert property (@(posedge clk) disable iff (rst)
    (!blink && step_i && !restart_i && nxt[WIDTH]) |=> (blink && led_o == {WIDTH{1'b1}}));

  // R6
  phase_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (blink && !restart_i && !phase_end) |=> $stable(led_o));

  // R8
  blink_not_cut_chk: assert property (@(posedge clk) disable iff (rst)
    (blink && !restart_i && !last) |=> blink);

  // R7
  blink_ends_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (blink && last && !restart_i) |=> (!blink && led_o == '0));
endmodule

// File: tb/fib_led_stepper_tb.sv
module fib_led_stepper_tb;
  localparam int W = 8;
  localparam int HOLD = 5;
  localparam int BL = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic step_i = 1'b0;
  logic restart_i = 1'b0;
  logic [W-1:0] led_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [W-1:0] exp_q[$];
  string        tag_q[$];

  int ma, mb, mph, mcnt;
  bit mblink;

  always #4 clk = ~clk;

  fib_led_stepper #(.WIDTH(W), .HOLD_CYCLES(HOLD), .BLINKS(BL)) u_dut (
    .clk(clk), .rst(rst), .step_i(step_i), .restart_i(restart_i), .led_o(led_o));

  function automatic logic [W-1:0] model_led();
    if (mblink) return (mph % 2 == 0) ? {W{1'b1}} : '0;
    return W'(ma);
  endfunction

  task automatic model_restart();
    ma = 0; mb = 1; mblink = 0; mph = 0; mcnt = 0;
  endtask

  task automatic cyc(input bit s, input bit r, input bit rs, input string tag);
    @(negedge clk);
    step_i = s; restart_i = r; rst = rs;
    if (r || rs) model_restart();
    else if (mblink) begin
      mcnt++;
      if (mcnt == HOLD) begin
        mcnt = 0; mph++;
        if (mph == 2 * BL) model_restart();
      end
    end else if (s) begin
      if (mb >= (1 << W)) begin mblink = 1; mph = 0; mcnt = 0; end
      else begin int t; t = ma + mb; ma = mb; mb = t; end
    end
    exp_q.push_back(model_led());
    tag_q.push_back(tag);
  endtask

  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [W-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (led_o !== e) begin
        errors++;
        $display("FAIL %s led_o=%0d expected=%0d at %0t", t, led_o, e, $time);
      end
    end
  end

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, tag);
  endtask

  initial begin
    model_restart();
    cyc(0, 0, 1, "R1");
    cyc(0, 0, 1, "R1");
    idle(3, "R1");
    for (int i = 0; i < 5; i++) begin
      cyc(1, 0, 0, "R2");
      idle(2, "R9");
    end
    cyc(0, 1, 0, "R3");
    idle(1, "R3");
    cyc(1, 0, 0, "R3");
    cyc(1, 0, 0, "R3");
    cyc(1, 1, 0, "R4");
    idle(1, "R4");
    for (int i = 0; i < 13; i++) cyc(1, 0, 0, "R2");
    idle(3, "R9");
    cyc(1, 0, 0, "R5");
    for (int i = 0; i < 2 * BL * HOLD - 1; i++)
      cyc((i % 3) == 1, 0, 0, (i % 3) == 1 ? "R8" : "R6");
    idle(2, "R7");
    cyc(1, 0, 0, "R7");
    cyc(1, 0, 0, "R7");
    cyc(1, 0, 0, "R7");
    cyc(0, 1, 0, "R1");
    for (int i = 0; i < 14; i++) cyc(1, 0, 0, "R5");
    idle(7, "R6");
    cyc(0, 1, 0, "R3");
    idle(2, "R3");
    for (int i = 0; i < 4; i++) cyc(1, 0, 0, "R2");
    cyc(0, 0, 1, "R1");
    idle(2, "R1");
    cyc(1, 0, 0, "R1");
    @(posedge clk);
    #3;
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule